// File: doc/BRIEF.md
# Minimal Single-Cycle RV64 Core

This block is a single-cycle 64-bit processor that runs a tiny subset of the RISC-V base integer set: `addi`, `add`, `jal`, `jalr`, and the all-stop word `unimp`. Every instruction completes in one clock. The fetch, the register reads, the add, the PC update and the register write-back all happen within one cycle. The core holds its own word-addressed instruction store, which is filled through a load port before execution starts. It also holds a program counter and a 32 x 64-bit register file in which x0 always reads as zero. The `li` pseudo-instruction runs as `addi` with x0 as its source.

An external enable input gates every state update, which gives the environment time to fill the instruction store before the program starts. Execution ends when the stop word is fetched. The halt output then stays high, and the PC and the registers hold their values until the next reset.

The datapath has four selectors:
- the first ALU operand comes from the PC or from rs1;
- the second ALU operand comes from rs2, the I-type immediate or the J-type immediate;
- the next PC is PC+4 or the computed jump target;
- the write-back data is the ALU sum or PC+4.

For debug, the core exposes the current PC, the instruction word, the three register numbers, and a third register-file read port.

Top module: `rv_mini_core`

## Requirements
- R1: After a synchronous active-low reset the PC is 0 and all 32 registers read 0.
- R2: While `en` is 0, neither the PC nor any register changes; execution advances one instruction per clock while `en` is 1.
- R3: `addi` (opcode 0010011, funct3 000) writes rs1 plus the sign-extended 12-bit immediate from bits 31:20 into rd, and the PC advances by 4; with rs1 = x0 this loads a constant.
- R4: `add` (opcode 0110011, funct3 000, funct7 0000000) writes rs1 + rs2 into rd, and the PC advances by 4.
- R5: `jal` (opcode 1101111) writes PC+4 into rd and sets the PC to PC plus the sign-extended J-type offset. The offset is formed as {bit31, bits19:12, bit20, bits30:21, 0}. Both forward and backward offsets work.
- R6: `jalr` (opcode 1100111, funct3 000) writes PC+4 into rd and sets the PC to (rs1 + I-immediate) with bit 0 cleared. The target uses the old rs1 value even when rd equals rs1.
- R7: Register x0 always reads 0, and writes aimed at it are discarded.
- R8: The word 0xC0001073 (`unimp`) raises `halt` for as long as it is the fetched word. It causes no register write, and the PC stays on it until reset.
- R9: Any other word writes no register and advances the PC by 4. An example is `add` with funct7 0100000.
- R10: `dbg_pc` and `dbg_iw` show the current PC and the fetched word. `dbg_rs1`, `dbg_rs2` and `dbg_rd` are bits 19:15, 24:20 and 11:7 of that word. `dbg_val` is the register selected by `dbg_sel`.
- R11: The load port writes `load_word` into instruction word `load_idx` on a clock edge, regardless of `en` and reset. The word at index i is fetched when the PC is 4*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables PC and register-file updates |
| load_we | input | 1 | Instruction-store write strobe |
| load_idx | input | IMEM_AW (6) | Instruction-store word index |
| load_word | input | 32 | Instruction word to store |
| halt | output | 1 | High while the fetched word is the stop word |
| dbg_pc | output | XLEN (64) | Current program counter |
| dbg_iw | output | 32 | Current instruction word |
| dbg_rs1 | output | 5 | rs1 field of the current word |
| dbg_rs2 | output | 5 | rs2 field of the current word |
| dbg_rd | output | 5 | rd field of the current word |
| dbg_sel | input | 5 | Register number for the debug read port |
| dbg_val | output | XLEN (64) | Value of the register selected by dbg_sel |

## Verification
Two functions can fall in the same cycle:
- a `jalr` whose destination is also its base register, which reads rs1 to form the target while writing the link into that same register;
- a link write in the same cycle as the jump it belongs to.

The bench provokes the first case with `jalr x1, 0(x1)` on an odd base value. It judges that the PC lands on the old value with bit 0 cleared, and that x1 ends up holding the link. The main call-and-return program stacks the link write, the PC redirect and a later return through the written register. An exhaustive sweep of all 4096 immediates pushes each value through `addi` from x0, through `addi` from a non-zero register, and through `add`. Every result is compared with sums computed in the bench.

// File: rtl/rv_mini_pkg.sv
// Shared constants and control types for the minimal single-cycle core.
// Assumes the 32-bit base encoding; only the fields needed by the subset appear.
package rv_mini_pkg;

    localparam logic [6:0]  OP_IMM   = 7'b0010011;
    localparam logic [6:0]  OP_REG   = 7'b0110011;
    localparam logic [6:0]  OP_JAL   = 7'b1101111;
    localparam logic [6:0]  OP_JALR  = 7'b1100111;
    localparam logic [31:0] WORD_STOP = 32'hC0001073;

    // Second ALU operand source
    typedef enum logic [1:0] {
        BSRC_REG   = 2'd0,
        BSRC_IMM_I = 2'd1,
        BSRC_IMM_J = 2'd2
    } bsrc_e;

    // Control bundle produced by the decoder
    typedef struct packed {
        logic  rf_we;      // write rd
        logic  a_from_pc;  // first ALU operand is the PC
        bsrc_e b_src;      // second ALU operand source
        logic  pc_jump;    // next PC is the ALU target
        logic  wd_link;    // write-back data is PC+4
        logic  stop;       // stop word fetched
    } ctl_t;

endpackage

// File: rtl/rv_mini_decode.sv
// Instruction decoder: maps a 32-bit word to the control bundle.
// Assumes the stop word is checked first; unknown words yield an all-zero
// bundle, which means no write and a sequential PC.
module rv_mini_decode
    import rv_mini_pkg::*;
(
    input  logic [31:0] iw,
    output ctl_t        ctl
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;

    assign opcode = iw[6:0];
    assign funct3 = iw[14:12];
    assign funct7 = iw[31:25];

    // Priority match of the supported words onto control values
    always_comb begin
        ctl       = '0;
        ctl.b_src = BSRC_REG;
        if (iw == WORD_STOP) begin
            ctl.stop = 1'b1;
        end else if (opcode == OP_IMM && funct3 == 3'b000) begin
            ctl.rf_we = 1'b1;
            ctl.b_src = BSRC_IMM_I;
        end else if (opcode == OP_REG && funct3 == 3'b000 && funct7 == 7'b0) begin
            ctl.rf_we = 1'b1;
        end else if (opcode == OP_JAL) begin
            ctl.rf_we     = 1'b1;
            ctl.a_from_pc = 1'b1;
            ctl.b_src     = BSRC_IMM_J;
            ctl.pc_jump   = 1'b1;
            ctl.wd_link   = 1'b1;
        end else if (opcode == OP_JALR && funct3 == 3'b000) begin
            ctl.rf_we   = 1'b1;
            ctl.b_src   = BSRC_IMM_I;
            ctl.pc_jump = 1'b1;
            ctl.wd_link = 1'b1;
        end
    end

endmodule

// File: rtl/rv_mini_imm.sv
// Immediate builder: reorders the I-type and J-type immediate fields and
// sign-extends them to XLEN. Assumes XLEN is at least 21.
module rv_mini_imm #(
    parameter int XLEN = 64
) (
    input  logic [31:12]     iw_hi,
    output logic [XLEN-1:0]  imm_i,
    output logic [XLEN-1:0]  imm_j
);

    localparam int I_FILL = XLEN - 12;
    localparam int J_FILL = XLEN - 21;

    // I-type: bits 31:20, sign in bit 31
    assign imm_i = {{I_FILL{iw_hi[31]}}, iw_hi[31:20]};

    // J-type: scattered offset, implicit zero in bit 0
    assign imm_j = {{J_FILL{iw_hi[31]}}, iw_hi[31], iw_hi[19:12],
                    iw_hi[20], iw_hi[30:21], 1'b0};

endmodule

// File: rtl/rv_mini_regfile.sv
// Register file with NRD combinational read ports and one synchronous write
// port. Entry 0 reads as zero and ignores writes. Synchronous active-low reset
// clears every entry.
module rv_mini_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int NRD  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [$clog2(NREG)-1:0]        wa,
    input  logic [XLEN-1:0]                wd,
    input  logic [NRD-1:0][$clog2(NREG)-1:0] ra,
    output logic [NRD-1:0][XLEN-1:0]       rd
);

    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] regs [NREG];

    // Reset clear and gated write, entry 0 excluded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // One read mux per port
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = (ra[g] == AW'(0)) ? '0 : regs[ra[g]];
    end

    // R7
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

    // R7
    zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra[0] == '0) |-> (rd[0] == '0));

endmodule

// File: rtl/rv_mini_core.sv
// Top of the minimal single-cycle core. Fetches from an internal word store
// indexed by PC[IMEM_AW+1:2], decodes, adds, and commits the PC and register
// write in one clock when en is high and the stop word is not fetched.
// Assumes the store is filled through the load port before en rises.
module rv_mini_core
    import rv_mini_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NREG       = 32,
    parameter int IMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          load_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] load_idx,
    input  logic [31:0]                   load_word,
    output logic                          halt,
    output logic [XLEN-1:0]               dbg_pc,
    output logic [31:0]                   dbg_iw,
    output logic [$clog2(NREG)-1:0]       dbg_rs1,
    output logic [$clog2(NREG)-1:0]       dbg_rs2,
    output logic [$clog2(NREG)-1:0]       dbg_rd,
    input  logic [$clog2(NREG)-1:0]       dbg_sel,
    output logic [XLEN-1:0]               dbg_val
);

    localparam int IMEM_AW = $clog2(IMEM_DEPTH);
    localparam int RAW     = $clog2(NREG);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    logic [31:0]            imem [IMEM_DEPTH];
    logic [XLEN-1:0]        pc_q;
    logic [31:0]            iw;
    ctl_t                   ctl;
    logic [XLEN-1:0]        imm_i, imm_j;
    logic [RAW-1:0]         rs1, rs2, rd;
    logic [2:0][RAW-1:0]    rf_ra;
    logic [2:0][XLEN-1:0]   rf_rd;
    logic [XLEN-1:0]        op_a, op_b, alu_out, pc_plus4, pc_next, wb_data;
    logic                   step;

    // Instruction store fill, independent of en and reset
    always_ff @(posedge clk) begin
        if (load_we) imem[load_idx] <= load_word;
    end

    assign iw  = imem[pc_q[IMEM_AW+1:2]];
    assign rs1 = iw[19:15];
    assign rs2 = iw[24:20];
    assign rd  = iw[11:7];

    rv_mini_decode u_dec (
        .iw  (iw),
        .ctl (ctl)
    );

    rv_mini_imm #(.XLEN(XLEN)) u_imm (
        .iw_hi (iw[31:12]),
        .imm_i (imm_i),
        .imm_j (imm_j)
    );

    assign rf_ra = {dbg_sel, rs2, rs1};

    rv_mini_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (step && ctl.rf_we),
        .wa    (rd),
        .wd    (wb_data),
        .ra    (rf_ra),
        .rd    (rf_rd)
    );

    // Operand selection and single adder
    always_comb begin
        op_a = ctl.a_from_pc ? pc_q : rf_rd[0];
        case (ctl.b_src)
            BSRC_REG:   op_b = rf_rd[1];
            BSRC_IMM_I: op_b = imm_i;
            BSRC_IMM_J: op_b = imm_j;
            default:    op_b = '0;
        endcase
        alu_out = op_a + op_b;
    end

    assign pc_plus4 = pc_q + PC_STEP;
    assign pc_next  = ctl.pc_jump ? {alu_out[XLEN-1:1], 1'b0} : pc_plus4;
    assign wb_data  = ctl.wd_link ? pc_plus4 : alu_out;
    assign step     = en && !ctl.stop;

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (step) pc_q <= pc_next;
    end

    assign halt    = ctl.stop;
    assign dbg_pc  = pc_q;
    assign dbg_iw  = iw;
    assign dbg_rs1 = rs1;
    assign dbg_rs2 = rs2;
    assign dbg_rd  = rd;
    assign dbg_val = rf_rd[2];

    // R2
    gate_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pc_q));

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(pc_q));

    // R9
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ctl.stop && !ctl.pc_jump) |=> (pc_q == $past(pc_q) + PC_STEP));

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.stop |-> (!ctl.rf_we && !ctl.pc_jump));

endmodule

// File: tb/rv_mini_core_test.sv
// Self-checking bench for rv_mini_core: encodes programs arithmetically,
// runs them, and compares registers and PC with values computed here.
module rv_mini_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        load_we = 1'b0;
    logic [5:0]  load_idx = '0;
    logic [31:0] load_word = '0;
    logic        halt;
    logic [63:0] dbg_pc;
    logic [31:0] dbg_iw;
    logic [4:0]  dbg_rs1, dbg_rs2, dbg_rd;
    logic [4:0]  dbg_sel = '0;
    logic [63:0] dbg_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] img [16];

    always #5 clk = ~clk;

    rv_mini_core uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .load_we(load_we), .load_idx(load_idx), .load_word(load_word),
        .halt(halt), .dbg_pc(dbg_pc), .dbg_iw(dbg_iw),
        .dbg_rs1(dbg_rs1), .dbg_rs2(dbg_rs2), .dbg_rd(dbg_rd),
        .dbg_sel(dbg_sel), .dbg_val(dbg_val)
    );

    function automatic logic [31:0] enc_i(int imm, int rs1, int rd, logic [6:0] op);
        logic [11:0] v = imm[11:0];
        return {v, rs1[4:0], 3'b000, rd[4:0], op};
    endfunction

    function automatic logic [31:0] enc_add(int rs2, int rs1, int rd);
        return {7'b0, rs2[4:0], rs1[4:0], 3'b000, rd[4:0], 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_jal(int off, int rd);
        logic [20:0] o = off[20:0];
        return {o[20], o[10:1], o[11], o[19:12], rd[4:0], 7'b1101111};
    endfunction

    localparam logic [31:0] STOP = 32'hC0001073;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input int idx, output logic [63:0] v);
        dbg_sel = idx[4:0];
        #1;
        v = dbg_val;
    endtask

    task automatic load_reset(input int n);
        rst_n = 1'b0;
        en = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_idx = i[5:0]; load_word = img[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt();
        en = 1'b1;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (halt) break;
        end
        en = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        longint e;

        // Main call-and-return program
        img[0] = enc_i(1, 0, 10, 7'b0010011);
        img[1] = enc_i(2, 0, 11, 7'b0010011);
        img[2] = enc_jal(8, 1);
        img[3] = STOP;
        img[4] = enc_add(11, 10, 10);
        img[5] = enc_i(0, 1, 0, 7'b1100111);
        load_reset(6);

        // R1 reset state
        chk(dbg_pc == 0, "R1 pc after reset", dbg_pc, 0);
        // R11 stored word visible at pc 0 while en is low
        chk(dbg_iw == img[0], "R11 loaded word fetched", dbg_iw, img[0]);
        // R2 enable low: nothing moves
        repeat (8) @(negedge clk);
        chk(dbg_pc == 0, "R2 pc held with en low", dbg_pc, 0);
        rd_reg(10, v);
        chk(v == 0, "R2 a0 unwritten with en low", v, 0);
        // R2 single step then stop
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        repeat (5) @(negedge clk);
        chk(dbg_pc == 4, "R2 pc after one enabled cycle", dbg_pc, 4);
        rd_reg(10, v);
        chk(v == 1, "R3 li a0", v, 1);
        rd_reg(11, v);
        chk(v == 0, "R2 a1 not yet written", v, 0);
        // R10 field outputs for addi a1,x0,2
        chk(dbg_iw == img[1], "R10 iw", dbg_iw, img[1]);
        chk(dbg_rd == 11, "R10 rd field", dbg_rd, 11);
        chk(dbg_rs1 == 0, "R10 rs1 field", dbg_rs1, 0);
        chk(dbg_rs2 == 2, "R10 rs2 field", dbg_rs2, 2);
        run_to_halt();
        rd_reg(10, v);
        chk(v == 3, "R4 R6 a0 after call and return", v, 3);
        rd_reg(1, v);
        chk(v == 12, "R5 ra link", v, 12);
        chk(dbg_pc == 12 && halt, "R8 halted at stop word", dbg_pc, 12);
        // R8 frozen even with en high
        en = 1'b1;
        repeat (10) @(negedge clk);
        en = 1'b0;
        chk(dbg_pc == 12, "R8 pc frozen", dbg_pc, 12);
        rd_reg(10, v);
        chk(v == 3, "R8 a0 frozen", v, 3);
        // R1 reset clears every register
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(dbg_pc == 0, "R1 pc cleared", dbg_pc, 0);
        for (int r = 0; r < 32; r++) begin
            rd_reg(r, v);
            chk(v == 0, "R1 register cleared", v, 0);
        end

        // R7 writes to x0 discarded
        img[0] = enc_i(5, 0, 0, 7'b0010011);
        img[1] = enc_i(0, 0, 6, 7'b0010011);
        img[2] = STOP;
        load_reset(3);
        run_to_halt();
        rd_reg(0, v);
        chk(v == 0, "R7 x0 reads zero", v, 0);
        rd_reg(6, v);
        chk(v == 0, "R7 x0 source gives zero", v, 0);

        // R5 backward jal
        img[0] = enc_jal(16, 0);
        img[1] = STOP;
        img[2] = enc_i(7, 0, 6, 7'b0010011);
        img[3] = STOP;
        img[4] = enc_jal(-8, 7);
        load_reset(5);
        run_to_halt();
        rd_reg(7, v);
        chk(v == 20, "R5 backward link", v, 20);
        rd_reg(6, v);
        chk(v == 7, "R5 backward target executed", v, 7);
        chk(dbg_pc == 12, "R5 final pc", dbg_pc, 12);

        // R6 jalr with rd == rs1 and odd base
        img[0] = enc_i(17, 0, 1, 7'b0010011);
        img[1] = enc_i(0, 1, 1, 7'b1100111);
        img[2] = STOP;
        img[3] = STOP;
        img[4] = enc_i(9, 0, 3, 7'b0010011);
        img[5] = STOP;
        load_reset(6);
        run_to_halt();
        rd_reg(1, v);
        chk(v == 8, "R6 link into base register", v, 8);
        rd_reg(3, v);
        chk(v == 9, "R6 target bit0 cleared", v, 9);
        chk(dbg_pc == 20, "R6 final pc", dbg_pc, 20);

        // R9 unsupported word (add with funct7 0100000)
        img[0] = enc_i(5, 0, 10, 7'b0010011);
        img[1] = {7'b0100000, 5'd10, 5'd0, 3'b000, 5'd10, 7'b0110011};
        img[2] = STOP;
        load_reset(3);
        run_to_halt();
        rd_reg(10, v);
        chk(v == 5, "R9 unsupported word writes nothing", v, 5);
        chk(dbg_pc == 8, "R9 unsupported word steps pc", dbg_pc, 8);

        // R3 R4 exhaustive immediate sweep
        for (int imm = -2048; imm < 2048; imm++) begin
            img[0] = enc_i(imm, 0, 5, 7'b0010011);
            img[1] = enc_i(imm, 5, 6, 7'b0010011);
            img[2] = enc_add(6, 5, 7);
            img[3] = STOP;
            load_reset(4);
            run_to_halt();
            e = imm;
            rd_reg(5, v);
            chk(v == 64'(e), "R3 sign-extended immediate", v, 64'(e));
            rd_reg(6, v);
            chk(v == 64'(2 * e), "R3 register plus immediate", v, 64'(2 * e));
            rd_reg(7, v);
            chk(v == 64'(3 * e), "R4 register sum", v, 64'(3 * e));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule